// File: doc/BRIEF.md
# Byte Table Lookup Unit

This unit forms a 32-bit result from four independent byte-wide indices. A local table of up to four 64-bit registers is loaded through a simple write port. For each byte lane of the index word, the unit checks the index against a table length supplied at run time. An index below that length selects one byte of the table. Any other index lets the matching byte of a default word pass through. The chosen byte lands in the lane of the index that chose it.

A lookup is requested with a one-cycle strobe. The four lane results are captured into an output register on that clock edge, so the result and its valid flag appear one cycle after the request. Table writes and lookups can happen in the same cycle; a lookup in that cycle sees the table as it was before the write.

Top module: `byte_lookup_unit`

## Requirements
- R1: Synchronous active-low reset clears every table register to zero and drives `res_valid` and `res_word` to 0. A lookup made just after reset therefore returns 0 in every lane whose index is in range.
- R2: `res_valid` is high in the cycle after each clock edge at which `req_valid` was high, and low in every other cycle.
- R3: Byte lane i of the result (bits 8i+7:8i) is decided only by index bits 8i+7:8i and by default-word bits 8i+7:8i, for i = 0 to 3.
- R4: A lane index n that is strictly less than `tbl_len` returns byte n[2:0] (bits 8·n[2:0]+7 : 8·n[2:0]) of table register n[4:3].
- R5: A lane index equal to or above `tbl_len`, including any value of 32 or more, returns the same lane of `dflt_word`.
- R6: When `wr_en` is high at a clock edge, all 64 bits of `wr_data` are stored into the table register chosen by `wr_sel` (values 0 to 3). The other registers keep their contents.
- R7: A lookup at the same edge as a table write uses the table contents from before that write. The new contents are used from the next lookup on.
- R8: `res_word` keeps its value across any clock edge at which `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write enable |
| wr_sel | input | 2 | Table register to write |
| wr_data | input | 64 | Table write data |
| req_valid | input | 1 | Lookup request strobe |
| idx_word | input | 32 | Four byte indices, lane 0 in bits 7:0 |
| dflt_word | input | 32 | Default bytes for out-of-range lanes |
| tbl_len | input | 6 | Table length in bytes (8, 16, 24 or 32) |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_word | output | 32 | Registered lookup result |

## Verification
Every table byte is loaded with a value that encodes its own index. A returned byte therefore shows which register and which offset were read, and a default byte can be told apart from a table byte. The vectors use every allowed table length. They include indices exactly at the length, just below it, at 32 and at 255, so an off-by-one in the bound or a truncated index shows up. They also use lane patterns where each lane differs from its neighbours, which exposes swapped or shared lanes. Directed cases cover a write issued together with a lookup, a rewrite of one register while its neighbours stay intact, idle cycles that must hold the result, and a reset in the middle of a run.

// File: rtl/byte_lookup_unit.sv
module byte_lookup_unit #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 64,
  parameter int LANES    = 4,
  parameter int SEL_W    = $clog2(NUM_REGS),
  parameter int LEN_W    = $clog2(NUM_REGS * (REG_W / 8) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               req_valid,
  input  logic [LANES*8-1:0] idx_word,
  input  logic [LANES*8-1:0] dflt_word,
  input  logic [LEN_W-1:0]   tbl_len,
  output logic               res_valid,
  output logic [LANES*8-1:0] res_word
);
  localparam int BPR       = REG_W / 8;
  localparam int OFS_W     = $clog2(BPR);
  localparam int TBL_BYTES = NUM_REGS * BPR;
  localparam int OUT_W     = LANES * 8;

  logic [REG_W-1:0] tbl [NUM_REGS];
  logic [OUT_W-1:0] pick;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0]       ix;
    logic             hit;
    logic [SEL_W-1:0] rsel;
    logic [OFS_W-1:0] bsel;
    logic [REG_W-1:0] row;

    assign ix   = idx_word[g*8 +: 8];
    assign hit  = (32'(ix) < 32'(tbl_len)) && (32'(ix) < 32'(TBL_BYTES));
    assign rsel = ix[OFS_W +: SEL_W];
    assign bsel = ix[OFS_W-1:0];
    assign row  = tbl[rsel];
    assign pick[g*8 +: 8] = hit ? row[{bsel, 3'b000} +: 8] : dflt_word[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) tbl[k] <= '0;
    end else if (wr_en) begin
      tbl[wr_sel] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_word <= pick;
    end
  end
endmodule

// File: rtl/byte_lookup_unit_chk.sv
module byte_lookup_unit_chk #(
  parameter int LANES = 4,
  parameter int LEN_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [LANES*8-1:0] idx_word,
  input logic [LANES*8-1:0] dflt_word,
  input logic [LEN_W-1:0]   tbl_len,
  input logic               res_valid,
  input logic [LANES*8-1:0] res_word
);
  logic run_q = 1'b0;
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    run_q <= rst_n;
    rst_q <= !rst_n;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst_q |-> (res_valid == 1'b0 && res_word == '0));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (res_valid == $past(req_valid)));

  p_dflt_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(req_valid) && (32'($past(idx_word[7:0])) >= 32'($past(tbl_len))))
      |-> (res_word[7:0] == $past(dflt_word[7:0])));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !$past(req_valid)) |-> $stable(res_word));
endmodule

bind byte_lookup_unit byte_lookup_unit_chk #(.LANES(LANES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .idx_word(idx_word),
  .dflt_word(dflt_word), .tbl_len(tbl_len), .res_valid(res_valid), .res_word(res_word)
);

// File: tb/tb_byte_lookup_unit.sv
module tb_byte_lookup_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] idx_word = '0;
  logic [31:0] dflt_word = '0;
  logic [5:0]  tbl_len = 6'd32;
  logic        res_valid;
  logic [31:0] res_word;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lookup_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .idx_word(idx_word), .dflt_word(dflt_word),
    .tbl_len(tbl_len), .res_valid(res_valid), .res_word(res_word)
  );

  // Table byte at index n holds 8'h40 + n.
  localparam logic [31:0] V_IDX [NV] = '{32'h03020100, 32'h07080F10, 32'h1F181710,
    32'h1F181710, 32'hFF80201F, 32'h00000007, 32'h09000809};
  localparam logic [31:0] V_DEF [NV] = '{32'hDDCCBBAA, 32'hDDCCBBAA, 32'hDDCCBBAA,
    32'hDDCCBBAA, 32'hDDCCBBAA, 32'h11223344, 32'h11223344};
  localparam logic [5:0]  V_LEN [NV] = '{6'd8, 6'd16, 6'd24, 6'd32, 6'd32, 6'd8, 6'd8};
  localparam logic [31:0] V_EXP [NV] = '{32'h43424140, 32'h47484FAA, 32'hDDCC5750,
    32'h5F585750, 32'hDDCCBB5F, 32'h40404047, 32'h11403344};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] idx, input logic [31:0] dft, input logic [5:0] len);
    @(negedge clk);
    req_valid = 1'b1; idx_word = idx; dflt_word = dft; tbl_len = len;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, res_valid}, 32'h0);
    check("R1 reset word", res_word, 32'h0);
    rst_n = 1'b1;
    lookup(32'h1F100803, 32'hFFFFFFFF, 6'd32);
    check("R1 cleared table", res_word, 32'h0);
    check("R2 valid after strobe", {31'b0, res_valid}, 32'h1);

    for (int k = 0; k < 4; k++)
      write_reg(2'(k), {8'(8'h47 + 8*k), 8'(8'h46 + 8*k), 8'(8'h45 + 8*k), 8'(8'h44 + 8*k),
                        8'(8'h43 + 8*k), 8'(8'h42 + 8*k), 8'(8'h41 + 8*k), 8'(8'h40 + 8*k)});

    // R3 R4 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      lookup(V_IDX[v], V_DEF[v], V_LEN[v]);
      check($sformatf("R3/R4/R5 vector %0d", v), res_word, V_EXP[v]);
      check("R2 valid per vector", {31'b0, res_valid}, 32'h1);
    end

    @(negedge clk);
    check("R2 valid drops", {31'b0, res_valid}, 32'h0);
    idx_word = 32'h00000000; dflt_word = 32'h0;
    @(negedge clk);
    check("R8 hold when idle", res_word, V_EXP[NV-1]);

    write_reg(2'd2, 64'h0123456789ABCDEF);
    lookup(32'h17100F08, 32'h0, 6'd32);
    check("R6 single register rewrite", res_word, 32'h01EF4F48);

    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'h8877665544332211;
    req_valid = 1'b1; idx_word = 32'h03020100; dflt_word = 32'h0; tbl_len = 6'd8;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R7 old contents in write cycle", res_word, 32'h43424140);
    lookup(32'h03020100, 32'h0, 6'd8);
    check("R7 new contents after write", res_word, 32'h44332211);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset word", res_word, 32'h0);
    rst_n = 1'b1;
    lookup(32'h18100800, 32'hFFFFFFFF, 6'd32);
    check("R1 table cleared by reset", res_word, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule